// File: doc/BRIEF.md
# DDS Phase Generator with Double-Buffered Controls

This block produces the running phase of a direct digital synthesizer. A host loads a frequency tuning word and a phase-clear flag into write buffers; nothing changes at the output until an update strobe copies both buffers into their active registers together. Every clock, the phase register either adds the active tuning word, wrapping modulo 2^32, or is held at zero while the active clear flag is set.

The upper 19 bits of the 32-bit phase go to a registered output that feeds a later angle-to-amplitude stage. Out of reset the active clear flag is set but its buffer is not. The phase therefore stays at zero until the host issues its first update strobe, whatever tuning word was written before it.

Top module: `dds_phase_gen`

## Requirements
- R1: A tuning-word write (`ftw_we_i` high) changes only the tuning-word buffer. Without an update strobe, the phase sequence at `phase_o` keeps using the previous active tuning word.
- R2: An `update_i` pulse at clock edge n copies both buffers into the active registers at edge n. A buffer write in the same cycle as the strobe is not copied by that strobe; it takes effect at the next strobe.
- R3: While the active clear flag is 0, each clock adds the active tuning word to the 32-bit phase register, modulo 2^32, with no saturation.
- R4: An active tuning word of zero holds the phase at its present value. It does not return the phase to zero.
- R5: While the active clear flag is 1, the phase register is loaded with zero. After the flag returns to 0, accumulation restarts from zero on the next clock.
- R6: Reset (`rst_ni` low) sets the active clear flag to 1, its buffer to 0, and both tuning-word registers to 0. `phase_o` reads 0 and stays 0 until the first update strobe.
- R7: `phase_o` equals bits 31..13 of the phase register, registered once. A change made active at edge n first affects the phase register at edge n+1 and first appears on `phase_o` at edge n+2.
- R8: A clear-flag write (`clr_we_i` high, value on `clr_i`) changes only the clear buffer and has no effect on `phase_o` until an update strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ftw_i | input | 32 | Tuning word to place in the buffer |
| ftw_we_i | input | 1 | Write strobe for the tuning-word buffer |
| clr_i | input | 1 | Phase-clear value to place in the buffer |
| clr_we_i | input | 1 | Write strobe for the clear buffer |
| update_i | input | 1 | Single-cycle strobe: buffers to active registers |
| phase_o | output | 19 | Truncated phase, upper 19 bits |

## Verification
A wrong active tuning word shows on `phase_o` as a wrong step size two clocks after the faulty transfer. Because the phase register integrates the error, the deviation grows every clock after that. A stuck or premature clear either freezes the output at zero or lets it move before the first update, and this is visible two clocks later. The bench uses small tuning words with steps of at least 2^13 so that every error in the phase register reaches the 19 visible bits. It also uses a word near 2^32 so that the wrap is exercised.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam int unsigned ACC_W = 32;
  localparam int unsigned OUT_W = 19;
endpackage

// File: rtl/dds_dbl_reg.sv
// Two-stage control register: host-loaded buffer plus active copy.
module dds_dbl_reg #(
  parameter int unsigned W        = 1,
  parameter logic [W-1:0] BUF_RST = '0,
  parameter logic [W-1:0] ACT_RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] wdata_i,
  input  logic         we_i,
  input  logic         update_i,
  output logic [W-1:0] buf_o,
  output logic [W-1:0] act_o
);
  logic [W-1:0] buf_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= BUF_RST;
    end else if (we_i) begin
      buf_q <= wdata_i;
    end
  end

  // active copy takes the pre-edge buffer, so a same-cycle write waits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= ACT_RST;
    end else if (update_i) begin
      act_q <= buf_q;
    end
  end

  assign buf_o = buf_q;
  assign act_o = act_q;
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] ftw_i,
  input  logic             clr_i,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] acc_q, acc_d;

  always_comb begin
    if (clr_i) acc_d = '0;
    else       acc_d = acc_q + ftw_i;  // wraps modulo 2^ACC_W
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/dds_phase_out.sv
module dds_phase_out #(
  parameter int unsigned ACC_W = 32,
  parameter int unsigned OUT_W = 19
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] acc_i,
  output logic [OUT_W-1:0] phase_o
);
  localparam int unsigned LSB = ACC_W - OUT_W;

  logic [OUT_W-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else         phase_q <= acc_i[ACC_W-1:LSB];
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/dds_phase_gen.sv
module dds_phase_gen
  import dds_pkg::*;
#(
  parameter int unsigned ACC_W_P = ACC_W,
  parameter int unsigned OUT_W_P = OUT_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ACC_W_P-1:0] ftw_i,
  input  logic               ftw_we_i,
  input  logic               clr_i,
  input  logic               clr_we_i,
  input  logic               update_i,
  output logic [OUT_W_P-1:0] phase_o
);
  logic [ACC_W_P-1:0] ftw_buf, ftw_act, acc_q;
  logic               clr_buf, clr_act;

  dds_dbl_reg #(.W(ACC_W_P), .BUF_RST('0), .ACT_RST('0)) i_ftw_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wdata_i  (ftw_i),
    .we_i     (ftw_we_i),
    .update_i (update_i),
    .buf_o    (ftw_buf),
    .act_o    (ftw_act)
  );

  // clear: buffer resets low, active resets high -> held at zero until first update
  dds_dbl_reg #(.W(1), .BUF_RST(1'b0), .ACT_RST(1'b1)) i_clr_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wdata_i  (clr_i),
    .we_i     (clr_we_i),
    .update_i (update_i),
    .buf_o    (clr_buf),
    .act_o    (clr_act)
  );

  dds_phase_acc #(.ACC_W(ACC_W_P)) i_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ftw_i  (ftw_act),
    .clr_i  (clr_act),
    .acc_o  (acc_q)
  );

  dds_phase_out #(.ACC_W(ACC_W_P), .OUT_W(OUT_W_P)) i_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .acc_i   (acc_q),
    .phase_o (phase_o)
  );
endmodule

// File: rtl/dds_phase_gen_chk.sv
module dds_phase_gen_chk #(
  parameter int unsigned ACC_W_P = 32,
  parameter int unsigned OUT_W_P = 19
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               update_i,
  input logic [ACC_W_P-1:0] ftw_buf,
  input logic [ACC_W_P-1:0] ftw_act,
  input logic               clr_buf,
  input logic               clr_act,
  input logic [ACC_W_P-1:0] acc_q,
  input logic [OUT_W_P-1:0] phase_o
);
  a_r1_hold_without_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_i |=> ($stable(ftw_act) && $stable(clr_act)));

  a_r2_copy_on_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i |=> (ftw_act == $past(ftw_buf) && clr_act == $past(clr_buf)));

  a_r3_accumulate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_act |=> acc_q == ACC_W_P'($past(acc_q) + $past(ftw_act)));

  a_r5_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_act |=> acc_q == '0);

  a_r7_trunc_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> phase_o == $past(acc_q[ACC_W_P-1 -: OUT_W_P]));
endmodule

bind dds_phase_gen dds_phase_gen_chk #(.ACC_W_P(ACC_W_P), .OUT_W_P(OUT_W_P)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .update_i (update_i),
  .ftw_buf  (ftw_buf),
  .ftw_act  (ftw_act),
  .clr_buf  (clr_buf),
  .clr_act  (clr_act),
  .acc_q    (acc_q),
  .phase_o  (phase_o)
);

// File: tb/test_dds_phase_gen.sv
module test_dds_phase_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] ftw_i = '0;
  logic        ftw_we_i = 1'b0;
  logic        clr_i = 1'b0;
  logic        clr_we_i = 1'b0;
  logic        update_i = 1'b0;
  logic [18:0] phase_o;

  typedef struct {
    logic [18:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int    n_chk = 0;
  int    n_fail = 0;
  string cur_tag = "R6";

  // requirement-level model state
  logic [31:0] m_ftw_buf = '0, m_ftw_act = '0, m_acc = '0;
  logic        m_clr_buf = 1'b0, m_clr_act = 1'b1;
  logic [18:0] m_out = '0;

  always #2.5 clk_i = ~clk_i;

  dds_phase_gen i_dds_phase_gen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ftw_i    (ftw_i),
    .ftw_we_i (ftw_we_i),
    .clr_i    (clr_i),
    .clr_we_i (clr_we_i),
    .update_i (update_i),
    .phase_o  (phase_o)
  );

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic check(input logic [18:0] act, input logic [18:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: phase_o=%h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: apply one cycle of stimulus, advance model, push expectation
  task automatic step(input logic [31:0] f, input logic fwe, input logic c,
                      input logic cwe, input logic upd);
    ftw_i = f; ftw_we_i = fwe; clr_i = c; clr_we_i = cwe; update_i = upd;
    @(posedge clk_i);
    m_out = m_acc[31:13];
    m_acc = m_clr_act ? 32'd0 : m_acc + m_ftw_act;
    if (upd) begin
      m_ftw_act = m_ftw_buf;
      m_clr_act = m_clr_buf;
    end
    if (fwe) m_ftw_buf = f;
    if (cwe) m_clr_buf = c;
    q.push_back('{exp: m_out, tag: cur_tag});
    @(negedge clk_i);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step('0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk_i);
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check(phase_o, it.exp, it.tag);
      end
    end
  end

  initial begin
    #100000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(phase_o, '0, "R6 reset");
    rst_ni = 1'b1;

    // R6 + R1: tuning word written, no update -> still zero
    cur_tag = "R6";
    step(32'h0004_0000, 1'b1, 1'b0, 1'b0, 1'b0);
    idle(5);

    // R2/R3/R7: first update activates word and releases clear
    cur_tag = "R2";
    step('0, 1'b0, 1'b0, 1'b0, 1'b1);
    cur_tag = "R3";
    idle(8);

    // R1: new word in buffer only
    cur_tag = "R1";
    step(32'h0010_0000, 1'b1, 1'b0, 1'b0, 1'b0);
    idle(4);

    // R2: write in same cycle as update -> old buffer copied
    cur_tag = "R2";
    step(32'h0000_2000, 1'b1, 1'b0, 1'b0, 1'b1);
    idle(4);
    step('0, 1'b0, 1'b0, 1'b0, 1'b1);
    cur_tag = "R7";
    idle(4);

    // R4: zero tuning word holds phase
    cur_tag = "R4";
    step(32'h0, 1'b1, 1'b0, 1'b0, 1'b0);
    step('0, 1'b0, 1'b0, 1'b0, 1'b1);
    idle(6);

    // R3: wrap modulo 2^32
    cur_tag = "R3 wrap";
    step(32'hF000_0000, 1'b1, 1'b0, 1'b0, 1'b0);
    step('0, 1'b0, 1'b0, 1'b0, 1'b1);
    idle(8);

    // R8: clear written to buffer only
    cur_tag = "R8";
    step('0, 1'b0, 1'b1, 1'b1, 1'b0);
    idle(4);

    // R5: clear activated, then released
    cur_tag = "R5";
    step(32'h0123_4000, 1'b1, 1'b0, 1'b0, 1'b1);
    idle(4);
    step('0, 1'b0, 1'b0, 1'b1, 1'b0);
    step('0, 1'b0, 1'b0, 1'b0, 1'b1);
    idle(6);

    repeat (3) @(negedge clk_i);
    finish_run();
  end
endmodule